// File: doc/BRIEF.md
# Serial Flash Request Sequencer

This block turns one high-level flash request into the full series of serial byte transfers needed to carry it out on an SPI NOR flash. Four request kinds are supported: a fast read of N bytes, a page program, an erase of one or more consecutive 4 KB sectors, and a whole-device erase. Every byte goes through a byte-level SPI master. The engine sends one byte per handshake and drives the chip select itself, so each command sits in its own select window.

Any request that modifies the array is preceded by a write-enable command in a separate window. After the modifying command, the engine reads the status byte repeatedly until the busy flag clears. Between a busy status read and the next one, the select line stays released for at least a parameterised number of cycles, so other masters can share the bus.

Program data enters through a valid/ready byte stream. Read data leaves as a stream of one-cycle valid beats. The engine pulses `done` once when a request is finished, and it accepts a new request only while idle.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset the engine is idle: `spi_cs_n` is 1, `busy`, `done`, `spi_start` and `dout_valid` are 0, and `req_ready` is 1.
- R2: A read request (`req_kind` = 0) produces exactly one select window: byte 0x0B, then the address high, middle and low bytes, then one filler byte 0xFF, then `req_len` filler bytes 0xFF. No write-enable window and no status window are produced.
- R3: For a read, the byte returned by the SPI master for each of the `req_len` data transfers appears on `dout_data` with a one-cycle `dout_valid` beat, in order, and nothing else appears.
- R4: A program request (`req_kind` = 1) produces a window holding only 0x06, then a window of 0x02, the request address with its low log2(PAGE_BYTES) bits cleared (high byte first), and PAGE_BYTES bytes taken in order from the `din` stream. A byte is taken only on a cycle where `din_valid` and `din_ready` are both 1.
- R5: A sector erase request (`req_kind` = 2) carries a sector number in `req_addr`. For each of `req_len` consecutive sectors (0 is treated as 1) it produces a 0x06 window, then a window of 0x20 and the 24-bit address sector<<12. Each sector finishes its status polling before the next sector's 0x06 window begins.
- R6: A chip erase request (`req_kind` = 3) produces a 0x06 window, then a window holding only 0xC7.
- R7: After each program or erase command window, the engine issues status windows of 0x05 followed by 0xFF. Another status window follows while bit 0 of the second received byte is 1. The request ends after the first status byte with bit 0 equal to 0, and the other status bits have no effect.
- R8: After a status read with bit 0 set, `spi_cs_n` stays 1 for at least GAP_CYCLES cycles before the next status window.
- R9: `done` is a one-cycle pulse given exactly once per accepted request. `busy` is 1 from acceptance through the `done` cycle and is 0 afterwards.
- R10: A request is taken only when `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only when idle. A request presented while busy has no effect on the transfers or outputs.
- R11: Only one byte is outstanding at a time (`spi_start` is never high on two consecutive cycles). Every byte is started with `spi_cs_n` at 0, and `spi_cs_n` returns to 1 for at least one cycle between windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | 24 | Byte address, or first sector number for sector erase |
| req_len | input | LEN_W | Read byte count, or sector count for sector erase |
| req_ready | output | 1 | Engine idle and able to take a request |
| din_data | input | 8 | Program data byte |
| din_valid | input | 1 | Program data byte present |
| din_ready | output | 1 | Engine can take a program byte |
| dout_data | output | 8 | Read data byte |
| dout_valid | output | 1 | Read data beat, one cycle |
| spi_start | output | 1 | Start one byte transfer on the SPI master |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Byte transfer finished |
| spi_rx | input | 8 | Byte shifted in, valid with spi_done |
| spi_cs_n | output | 1 | Flash chip select, active low |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished, one cycle |

## Verification
The hardest case to reach from the ports is a multi-sector erase in which the flash reports busy several times per sector, combined with a new request presented during the busy phase. Both the ordering of write-enable after completed polling and the ignoring of the extra request must then be shown. The bench's flash model reloads a chosen busy-poll count whenever a modifying command window closes. It returns random upper status bits, varies the byte latency at random, and stalls the program stream at random. The bench then presents a read request in the middle of a polled chip erase and compares the complete logged byte stream, window boundaries included, with the expected one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        REQ_READ   = 2'd0,
        REQ_PROG   = 2'd1,
        REQ_SERASE = 2'd2,
        REQ_CERASE = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        PH_WREN = 2'd0,
        PH_CMD  = 2'd1,
        PH_POLL = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_XFER  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DESEL = 3'd4,
        ST_GAP   = 3'd5,
        ST_DONE  = 3'd6
    } state_e;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'h20;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] FILLER    = 8'hFF;

    function automatic logic [7:0] cmd_opcode(req_kind_e k);
        case (k)
            REQ_READ:   return OP_FREAD;
            REQ_PROG:   return OP_PROG;
            REQ_SERASE: return OP_SERASE;
            default:    return OP_CERASE;
        endcase
    endfunction

    // Opcode plus address plus (for fast read) one dummy byte.
    function automatic logic [2:0] cmd_header(req_kind_e k);
        case (k)
            REQ_READ:   return 3'd5;
            REQ_PROG:   return 3'd4;
            REQ_SERASE: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/flash_txn_builder.sv
module flash_txn_builder
    import flash_seq_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 256,
    parameter int IDX_W      = 14
) (
    input  phase_e              phase,
    input  req_kind_e           kind,
    input  logic [23:0]         addr,
    input  logic [LEN_W-1:0]    len,
    input  logic [IDX_W-1:0]    idx,
    input  logic [7:0]          din_data,
    output logic [7:0]          tx_byte,
    output logic [IDX_W-1:0]    last_idx,
    output logic                in_data,
    output logic                takes_din
);

    logic [IDX_W-1:0] hdr;
    logic [IDX_W-1:0] ndata;

    always_comb begin
        case (phase)
            PH_WREN: begin
                hdr   = IDX_W'(1);
                ndata = '0;
            end
            PH_POLL: begin
                hdr   = IDX_W'(1);
                ndata = IDX_W'(1);
            end
            default: begin
                hdr = IDX_W'(cmd_header(kind));
                if (kind == REQ_READ)
                    ndata = IDX_W'(len);
                else if (kind == REQ_PROG)
                    ndata = IDX_W'(PAGE_BYTES);
                else
                    ndata = '0;
            end
        endcase
    end

    assign last_idx  = hdr + ndata - IDX_W'(1);
    assign in_data   = (idx >= hdr);
    assign takes_din = (phase == PH_CMD) && (kind == REQ_PROG) && in_data;

    always_comb begin
        tx_byte = FILLER;
        case (phase)
            PH_WREN: tx_byte = OP_WREN;
            PH_POLL: tx_byte = (idx == '0) ? OP_STATUS : FILLER;
            default: begin
                if (idx == '0)
                    tx_byte = cmd_opcode(kind);
                else if (!in_data) begin
                    case (idx)
                        IDX_W'(1): tx_byte = addr[23:16];
                        IDX_W'(2): tx_byte = addr[15:8];
                        IDX_W'(3): tx_byte = addr[7:0];
                        default:   tx_byte = FILLER;
                    endcase
                end else if (takes_din)
                    tx_byte = din_data;
                else
                    tx_byte = FILLER;
            end
        endcase
    end

endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
    parameter int GAP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    localparam int GW = $clog2(GAP_CYCLES + 2);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= GW'(GAP_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - GW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/flash_rx_capture.sv
module flash_rx_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_done,
    input  logic [7:0] spi_rx,
    input  logic       grab_data,
    input  logic       grab_status,
    output logic       dout_valid,
    output logic [7:0] dout_data,
    output logic       wip
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_valid <= 1'b0;
            dout_data  <= '0;
            wip        <= 1'b0;
        end else begin
            dout_valid <= spi_done && grab_data;
            if (spi_done && grab_data)
                dout_data <= spi_rx;
            if (spi_done && grab_status)
                wip <= spi_rx[0];
        end
    end

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
    import flash_seq_pkg::*;
#(
    parameter int LEN_W        = 12,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_SHIFT = 12,
    parameter int GAP_CYCLES   = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic [7:0]       din_data,
    input  logic             din_valid,
    output logic             din_ready,
    output logic [7:0]       dout_data,
    output logic             dout_valid,
    output logic             spi_start,
    output logic [7:0]       spi_tx,
    input  logic             spi_done,
    input  logic [7:0]       spi_rx,
    output logic             spi_cs_n,
    output logic             busy,
    output logic             done
);

    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int IDX_BASE   = (LEN_W > PAGE_SHIFT + 1) ? LEN_W : PAGE_SHIFT + 1;
    localparam int IDX_W      = IDX_BASE + 1;
    localparam logic [23:0] PAGE_MASK    = 24'(PAGE_BYTES - 1);
    localparam logic [23:0] SECTOR_BYTES = 24'(1) << SECTOR_SHIFT;

    state_e           state;
    phase_e           phase;
    req_kind_e        kind;
    logic [23:0]      addr;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] remain;
    logic [IDX_W-1:0] idx;

    logic [7:0]       tx_byte;
    logic [IDX_W-1:0] last_idx;
    logic             in_data;
    logic             takes_din;
    logic             wip;
    logic             gap_load;
    logic             gap_expired;
    logic             accept;
    req_kind_e        new_kind;

    flash_txn_builder #(
        .LEN_W     (LEN_W),
        .PAGE_BYTES(PAGE_BYTES),
        .IDX_W     (IDX_W)
    ) u_builder (
        .phase    (phase),
        .kind     (kind),
        .addr     (addr),
        .len      (len),
        .idx      (idx),
        .din_data (din_data),
        .tx_byte  (tx_byte),
        .last_idx (last_idx),
        .in_data  (in_data),
        .takes_din(takes_din)
    );

    flash_rx_capture u_rx (
        .clk        (clk),
        .rst        (rst),
        .spi_done   (spi_done),
        .spi_rx     (spi_rx),
        .grab_data  ((state == ST_WAIT) && (phase == PH_CMD) && (kind == REQ_READ) && in_data),
        .grab_status((state == ST_WAIT) && (phase == PH_POLL) && in_data),
        .dout_valid (dout_valid),
        .dout_data  (dout_data),
        .wip        (wip)
    );

    assign gap_load = (state == ST_DESEL) && (phase == PH_POLL) && wip;

    flash_gap_timer #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load   (gap_load),
        .expired(gap_expired)
    );

    assign new_kind = req_kind_e'(req_kind);
    assign accept   = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= PH_CMD;
            kind   <= REQ_READ;
            addr   <= '0;
            len    <= '0;
            remain <= '0;
            idx    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        kind   <= new_kind;
                        len    <= req_len;
                        remain <= (req_len == '0) ? LEN_W'(1) : req_len;
                        idx    <= '0;
                        phase  <= (new_kind == REQ_READ) ? PH_CMD : PH_WREN;
                        state  <= ST_SEL;
                        case (new_kind)
                            REQ_READ:   addr <= req_addr;
                            REQ_PROG:   addr <= req_addr & ~PAGE_MASK;
                            REQ_SERASE: addr <= req_addr << SECTOR_SHIFT;
                            default:    addr <= '0;
                        endcase
                    end
                end
                ST_SEL:  state <= ST_XFER;
                ST_XFER: if (spi_start) state <= ST_WAIT;
                ST_WAIT: begin
                    if (spi_done) begin
                        if (idx == last_idx)
                            state <= ST_DESEL;
                        else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_XFER;
                        end
                    end
                end
                ST_DESEL: begin
                    idx <= '0;
                    case (phase)
                        PH_WREN: begin
                            phase <= PH_CMD;
                            state <= ST_SEL;
                        end
                        PH_CMD: begin
                            if (kind == REQ_READ)
                                state <= ST_DONE;
                            else begin
                                phase <= PH_POLL;
                                state <= ST_SEL;
                            end
                        end
                        default: begin
                            if (wip)
                                state <= ST_GAP;
                            else if ((kind == REQ_SERASE) && (remain > LEN_W'(1))) begin
                                remain <= remain - LEN_W'(1);
                                addr   <= addr + SECTOR_BYTES;
                                phase  <= PH_WREN;
                                state  <= ST_SEL;
                            end else
                                state <= ST_DONE;
                        end
                    endcase
                end
                ST_GAP:  if (gap_expired) state <= ST_SEL;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_n  = !((state == ST_SEL) || (state == ST_XFER) || (state == ST_WAIT));
    assign spi_start = (state == ST_XFER) && (!takes_din || din_valid);
    assign spi_tx    = tx_byte;
    assign din_ready = (state == ST_XFER) && takes_din;
    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/flash_seq_checks.sv
module flash_seq_checks (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic din_ready,
    input logic dout_valid,
    input logic spi_start,
    input logic spi_cs_n,
    input logic busy,
    input logic done
);

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n && !spi_start && !dout_valid)); // R1

    AST_DOUT_IN_REQUEST: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> busy); // R3

    AST_DIN_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> !spi_cs_n); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R9

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !busy); // R10

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy); // R10

    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        spi_start |-> !spi_cs_n); // R11

    AST_ONE_BYTE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start); // R11

endmodule

bind flash_seq_engine flash_seq_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .din_ready (din_ready),
    .dout_valid(dout_valid),
    .spi_start (spi_start),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_flash_seq_engine.sv
`timescale 1ns/1ps
module tb_flash_seq_engine;

    localparam int LEN_W = 12;
    localparam int PAGE  = 256;
    localparam int GAP   = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = 2'd0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready;
    logic [7:0]       din_data = '0;
    logic             din_valid = 1'b0;
    logic             din_ready;
    logic [7:0]       dout_data;
    logic             dout_valid;
    logic             spi_start;
    logic [7:0]       spi_tx;
    logic             spi_done = 1'b0;
    logic [7:0]       spi_rx = '0;
    logic             spi_cs_n;
    logic             busy;
    logic             done;

    always #2 clk = ~clk;

    flash_seq_engine #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .SECTOR_SHIFT(12), .GAP_CYCLES(GAP)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
        .dout_data(dout_data), .dout_valid(dout_valid), .spi_start(spi_start),
        .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
        .spi_cs_n(spi_cs_n), .busy(busy), .done(done)
    );

    int nchk = 0;
    int nfail = 0;

    function automatic logic [7:0] rd_pat(logic [23:0] a, int k);
        return 8'(a[7:0] + a[15:8] + 8'(k * 7)) ^ 8'hC3;
    endfunction

    logic [7:0] pkey = 8'h00;
    function automatic logic [7:0] prog_pat(int k, logic [7:0] key);
        return 8'(k * 29 + 11) ^ key;
    endfunction

    // ---------------- flash / SPI master model ----------------
    logic [8:0] txlog [0:4095];
    int         txn = 0;
    logic [7:0] wbyte [0:7];
    int         widx = 0;
    logic       first = 1'b1;
    logic       pend = 1'b0;
    int         lat = 0;
    logic [7:0] rxv = '0;
    logic       prev_cs = 1'b1;
    int         hi_cnt = 0;
    logic       busy_flag = 1'b0;
    int         busy_polls = 0;
    int         polls_left = 0;
    int         busy_gaps = 0;
    int         gap_viol = 0;
    logic [7:0] op_now;

    always @(posedge clk) begin
        if (rst) begin
            spi_done  <= 1'b0;
            pend      <= 1'b0;
            first     <= 1'b1;
            widx      <= 0;
            prev_cs   <= 1'b1;
            hi_cnt    <= 0;
            busy_flag <= 1'b0;
        end else begin
            prev_cs  <= spi_cs_n;
            spi_done <= 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    spi_done <= 1'b1;
                    spi_rx   <= rxv;
                    pend     <= 1'b0;
                end else
                    lat <= lat - 1;
            end
            if (spi_cs_n) begin
                first  <= 1'b1;
                widx   <= 0;
                hi_cnt <= hi_cnt + 1;
                if (!prev_cs && (wbyte[0] == 8'h02 || wbyte[0] == 8'h20 || wbyte[0] == 8'hC7))
                    polls_left <= busy_polls;
            end else if (prev_cs) begin
                if (busy_flag) begin
                    busy_gaps <= busy_gaps + 1;
                    if (hi_cnt < GAP) gap_viol <= gap_viol + 1;
                end
                busy_flag <= 1'b0;
                hi_cnt    <= 0;
            end
            if (spi_start) begin
                op_now = first ? spi_tx : wbyte[0];
                txlog[txn] <= {first, spi_tx};
                txn        <= txn + 1;
                first      <= 1'b0;
                if (widx < 8) wbyte[widx] <= spi_tx;
                widx <= widx + 1;
                pend <= 1'b1;
                lat  <= int'($urandom % 3);
                if (widx == 0)
                    rxv <= 8'($urandom);
                else if (op_now == 8'h05 && widx == 1) begin
                    rxv <= {7'($urandom), polls_left != 0};
                    if (polls_left != 0) begin
                        polls_left <= polls_left - 1;
                        busy_flag  <= 1'b1;
                    end
                end else if (op_now == 8'h0B && widx >= 5)
                    rxv <= rd_pat({wbyte[1], wbyte[2], wbyte[3]}, widx - 5);
                else
                    rxv <= 8'($urandom);
            end
        end
    end

    // ---------------- program data source ----------------
    int din_idx = 0;
    int din_base = 0;
    always @(posedge clk)
        if (din_valid && din_ready) din_idx <= din_idx + 1;
    always @(negedge clk) begin
        din_valid = !rst && ($urandom % 4 != 0);
        din_data  = prog_pat(din_idx - din_base, pkey);
    end

    // ---------------- output monitor ----------------
    logic [7:0] rd_buf [0:4095];
    int rd_n = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt = done_cnt + 1;
            if (dout_valid) begin
                rd_buf[rd_n] = dout_data;
                rd_n = rd_n + 1;
            end
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    logic [8:0] expq [0:4095];
    int expn = 0;

    task automatic exp_add(input bit f, input logic [7:0] b);
        expq[expn] = {f, b};
        expn++;
    endtask

    task automatic exp_addr(input logic [23:0] a);
        exp_add(0, a[23:16]); exp_add(0, a[15:8]); exp_add(0, a[7:0]);
    endtask

    task automatic exp_polls(input int b);
        for (int i = 0; i <= b; i++) begin
            exp_add(1, 8'h05); exp_add(0, 8'hFF);
        end
    endtask

    task automatic cmp_stream(input string tag, input int base);
        int mm = -1;
        chk(txn - base == expn, tag, "byte count", txn - base, expn);
        for (int i = 0; i < expn && i < txn - base; i++)
            if (mm < 0 && txlog[base + i] !== expq[i]) mm = i;
        if (mm < 0) chk(1, tag, "stream", 0, 0);
        else chk(0, tag, $sformatf("stream byte %0d (bit8=window start)", mm),
                 txlog[base + mm], expq[mm]);
    endtask

    int base, d0, r0, g0, v0;

    task automatic start_req(input logic [1:0] k, input logic [23:0] a, input logic [LEN_W-1:0] n);
        expn = 0;
        base = txn; d0 = done_cnt; r0 = rd_n; g0 = busy_gaps; v0 = gap_viol;
        din_base = din_idx;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (done_cnt == d0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9", {tag, " done pulses"}, done_cnt - d0, 1);
        chk(!busy && req_ready, "R9", {tag, " idle after done"}, busy, 0);
    endtask

    task automatic do_read(input logic [23:0] a, input int n);
        start_req(2'd0, a, LEN_W'(n));
        exp_add(1, 8'h0B); exp_addr(a); exp_add(0, 8'hFF);
        for (int i = 0; i < n; i++) exp_add(0, 8'hFF);
        wait_done("read");
        cmp_stream("R2", base);
        chk(rd_n - r0 == n, "R3", "read beat count", rd_n - r0, n);
        begin
            int bad = -1;
            for (int i = 0; i < n && i < rd_n - r0; i++)
                if (bad < 0 && rd_buf[r0 + i] !== rd_pat(a, i)) bad = i;
            if (bad < 0) chk(1, "R3", "read data", 0, 0);
            else chk(0, "R3", $sformatf("read data %0d", bad), rd_buf[r0 + bad], rd_pat(a, bad));
        end
    endtask

    task automatic do_prog(input logic [23:0] a, input int b);
        logic [23:0] pa;
        busy_polls = b;
        pkey = 8'($urandom);
        pa = {a[23:8], 8'h00};
        start_req(2'd1, a, '0);
        exp_add(1, 8'h06);
        exp_add(1, 8'h02); exp_addr(pa);
        for (int i = 0; i < PAGE; i++) exp_add(0, prog_pat(i, pkey));
        exp_polls(b);
        wait_done("program");
        cmp_stream("R4", base);
        chk(busy_gaps - g0 == b, "R7", "busy status reads", busy_gaps - g0, b);
        chk(gap_viol == v0, "R8", "short gap after busy status", gap_viol - v0, 0);
    endtask

    task automatic do_serase(input logic [11:0] sec, input int n, input int b);
        int cnt;
        busy_polls = b;
        cnt = (n == 0) ? 1 : n;
        start_req(2'd2, {12'h000, sec}, LEN_W'(n));
        for (int s = 0; s < cnt; s++) begin
            exp_add(1, 8'h06);
            exp_add(1, 8'h20); exp_addr(24'((int'(sec) + s) << 12));
            exp_polls(b);
        end
        wait_done("sector erase");
        cmp_stream("R5", base);
        chk(busy_gaps - g0 == b * cnt, "R7", "busy status reads", busy_gaps - g0, b * cnt);
        chk(gap_viol == v0, "R8", "short gap after busy status", gap_viol - v0, 0);
    endtask

    initial begin
        #(4 * 190000);
        nfail++; nchk++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C4B));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(!spi_start && !dout_valid, "R1", "start/dout after reset", {spi_start, dout_valid}, 0);

        // Reads: zero length, single byte, top of address space, random.
        do_read(24'h000000, 0);
        do_read(24'hFFFFFF, 1);
        do_read(24'h0A5501, 3);
        for (int i = 0; i < 6; i++)
            do_read(24'($urandom), int'($urandom % 40) + 1);

        // Program: unaligned address is page-aligned; with and without busy status.
        do_prog(24'h0123AB, 0);
        do_prog(24'($urandom), 3);

        // Sector erase: zero count means one, highest sector, multi-sector with polling.
        do_serase(12'hFFF, 0, 2);
        do_serase(12'($urandom), 3, 1);

        // Chip erase with a request presented while busy (R10).
        busy_polls = 4;
        start_req(2'd3, 24'h000000, '0);
        exp_add(1, 8'h06);
        exp_add(1, 8'hC7);
        exp_polls(4);
        repeat (30) @(negedge clk);
        chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 24'h111111; req_len = 12'd5;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done("chip erase");
        cmp_stream("R6", base);
        chk(rd_n == r0, "R10", "no read beats from ignored request", rd_n - r0, 0);
        chk(busy_gaps - g0 == 4, "R7", "busy status reads", busy_gaps - g0, 4);
        chk(gap_viol == v0, "R8", "short gap after busy status", gap_viol - v0, 0);

        // Engine keeps working after the ignored request; window framing (R11).
        do_read(24'h00FF00, 8);
        chk(spi_cs_n == 1'b1, "R11", "cs released when idle", spi_cs_n, 1);

        finish_run();
    end

endmodule